// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Register Bank

This block is the register file in front of a multi-channel pulse-width modulator. A processor reaches it over a simple memory-mapped bus with a byte address, separate write and read strobes and 32-bit data. The block keeps a global mode word and, for each channel, an enable bit, an interrupt mask bit, a pending-event bit and three storage registers (mode, duty, period). These registers drive the waveform generators. It also returns each channel's live counter value on a read.

Enable and mask bits are never written directly. A one written to a "set" address turns a bit on, and a one written to the matching "clear" address turns it off. Each channel counter sends a one-cycle end-of-period pulse. The block latches that pulse as a pending bit. Reading the status word returns the pending bits and clears them. A single registered interrupt line is high while any pending channel is also unmasked.

Top module: `pwm_ctl_regs`

## Requirements
- R1: A write to 0x04 sets every channel enable bit whose data bit is 1. A write to 0x08 clears every enable bit whose data bit is 1. Zero data bits leave a bit unchanged. A read of 0x0C returns the enable bits in data bits [NCH-1:0]. Output `chan_en` shows them.
- R2: A write to 0x10 sets the mask bits selected by ones. A write to 0x14 clears them. Zero data bits have no effect. A read of 0x18 returns the mask in bits [NCH-1:0].
- R3: A 1 on `period_end[n]` at a rising clock edge sets pending bit n at that edge.
- R4: A read of 0x1C returns the pending bits in bits [NCH-1:0] and clears them. An event that arrives in the same cycle as that read stays pending.
- R5: After every clock edge, `irq` equals the OR over channels of (pending AND mask) as they stand after that edge.
- R6: The 32-bit mode word at 0x00 is read/write.
- R7: Channel n's registers are at 0x200 + 0x20*n. The mode register (low CM_W bits) is at +0x0, duty (low DW bits) at +0x4 and period (low DW bits) at +0x8. Each is read/write and drives `chan_mode`, `chan_duty` and `chan_period` (channel n in slice n).
- R8: A read of channel offset +0xC returns that channel's slice of `chan_count`. Writes to it have no effect.
- R9: Reads return 0 at write-only addresses (0x04, 0x08, 0x10, 0x14, channel +0x10), at reserved addresses, at addresses that are not word aligned, and at channel slots n >= NCH. Writes to read-only or reserved addresses change nothing.
- R10: `bus_rdata` carries the read value in the cycle after the cycle in which `bus_rd` was high. In every other cycle it is 0.
- R11: Reset (`rst_n` low, asynchronous) clears every register, `irq` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| period_end | input | NCH | End-of-period pulse per channel |
| chan_count | input | NCH*DW | Live counter value per channel |
| chan_en | output | NCH | Channel enable bits |
| chan_mode | output | NCH*CM_W | Per-channel mode register |
| chan_duty | output | NCH*DW | Per-channel duty register |
| chan_period | output | NCH*DW | Per-channel period register |
| irq | output | 1 | Registered interrupt request |

## Verification
A status read and an end-of-period pulse can land in the same cycle, and this collision decides whether an event is lost. The bench forces it on purpose by pulsing a channel while it reads 0x1C. It expects the read to return the old pending bits, the fresh bit to stay set, and `irq` to stay high. Random traffic also mixes event pulses with status reads. Every read result and every per-cycle `irq` value is compared against a model that applies "read clears, then the new event sets".

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;

    // global register offsets
    localparam int unsigned OFS_MODE = 'h00;
    localparam int unsigned OFS_ENA  = 'h04;
    localparam int unsigned OFS_DIS  = 'h08;
    localparam int unsigned OFS_SR   = 'h0C;
    localparam int unsigned OFS_IER  = 'h10;
    localparam int unsigned OFS_IDR  = 'h14;
    localparam int unsigned OFS_IMR  = 'h18;
    localparam int unsigned OFS_ISR  = 'h1C;

    // per-channel window
    localparam int unsigned CH_BASE   = 'h200;
    localparam int unsigned CH_SLOT_LG = 5;

    localparam int unsigned COFS_MODE = 'h00;
    localparam int unsigned COFS_DUTY = 'h04;
    localparam int unsigned COFS_PRD  = 'h08;
    localparam int unsigned COFS_CNT  = 'h0C;
    localparam int unsigned COFS_UPD  = 'h10;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_ENA,
        SEL_DIS,
        SEL_SR,
        SEL_IER,
        SEL_IDR,
        SEL_IMR,
        SEL_ISR,
        SEL_CMODE,
        SEL_CDUTY,
        SEL_CPRD,
        SEL_CCNT,
        SEL_CUPD
    } reg_sel_e;

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_ctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [CH_W-1:0]   chan
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        sel  = SEL_NONE;
        chan = '0;
        rel  = addr - ADDR_W'(CH_BASE);
        slot = rel >> CH_SLOT_LG;
        if (addr[1:0] == 2'b00) begin
            if (addr < ADDR_W'(CH_BASE)) begin
                case (addr)
                    ADDR_W'(OFS_MODE): sel = SEL_MODE;
                    ADDR_W'(OFS_ENA):  sel = SEL_ENA;
                    ADDR_W'(OFS_DIS):  sel = SEL_DIS;
                    ADDR_W'(OFS_SR):   sel = SEL_SR;
                    ADDR_W'(OFS_IER):  sel = SEL_IER;
                    ADDR_W'(OFS_IDR):  sel = SEL_IDR;
                    ADDR_W'(OFS_IMR):  sel = SEL_IMR;
                    ADDR_W'(OFS_ISR):  sel = SEL_ISR;
                    default:           sel = SEL_NONE;
                endcase
            end else if (slot < ADDR_W'(NCH)) begin
                chan = slot[CH_W-1:0];
                case (rel[CH_SLOT_LG-1:0])
                    CH_SLOT_LG'(COFS_MODE): sel = SEL_CMODE;
                    CH_SLOT_LG'(COFS_DUTY): sel = SEL_CDUTY;
                    CH_SLOT_LG'(COFS_PRD):  sel = SEL_CPRD;
                    CH_SLOT_LG'(COFS_CNT):  sel = SEL_CCNT;
                    CH_SLOT_LG'(COFS_UPD):  sel = SEL_CUPD;
                    default:                sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_ctl_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2,
    parameter int CM_W = 11,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [CH_W-1:0]   chan,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*CM_W-1:0] mode_o,
    output logic [NCH*DW-1:0]   duty_o,
    output logic [NCH*DW-1:0]   prd_o
);

    typedef struct packed {
        logic [NCH-1:0][CM_W-1:0] mode;
        logic [NCH-1:0][DW-1:0]   duty;
        logic [NCH-1:0][DW-1:0]   prd;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CMODE: st_d.mode[chan] = wdata[CM_W-1:0];
                SEL_CDUTY: st_d.duty[chan] = wdata;
                SEL_CPRD:  st_d.prd[chan]  = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign mode_o[i*CM_W +: CM_W] = st_q.mode[i];
        assign duty_o[i*DW +: DW]     = st_q.duty[i];
        assign prd_o[i*DW +: DW]      = st_q.prd[i];
    end

endmodule

// File: rtl/pwm_irq_ctl.sv
module pwm_irq_ctl
    import pwm_ctl_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  reg_sel_e       sel,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] period_end,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] pend_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] pend;
        logic           irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_ENA: st_d.en   = st_q.en | wbits;
                SEL_DIS: st_d.en   = st_q.en & ~wbits;
                SEL_IER: st_d.mask = st_q.mask | wbits;
                SEL_IDR: st_d.mask = st_q.mask & ~wbits;
                default: ;
            endcase
        end
        // clear-on-read first, then the new event sets: no event is lost
        if (rd_en && sel == SEL_ISR) st_d.pend = period_end;
        else                         st_d.pend = st_q.pend | period_end;
        st_d.irq = |(st_d.pend & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
    import pwm_ctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int CM_W   = 11,
    parameter int DW     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NCH-1:0]       period_end,
    input  logic [NCH*DW-1:0]    chan_count,
    output logic [NCH-1:0]       chan_en,
    output logic [NCH*CM_W-1:0]  chan_mode,
    output logic [NCH*DW-1:0]    chan_duty,
    output logic [NCH*DW-1:0]    chan_period,
    output logic                 irq
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    reg_sel_e        sel;
    logic [CH_W-1:0] chan;
    logic [NCH-1:0]  irq_mask;
    logic [NCH-1:0]  irq_pend;

    pwm_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .chan (chan)
    );

    pwm_chan_regs #(.NCH(NCH), .CH_W(CH_W), .CM_W(CM_W), .DW(DW)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .sel    (sel),
        .chan   (chan),
        .wdata  (bus_wdata[DW-1:0]),
        .mode_o (chan_mode),
        .duty_o (chan_duty),
        .prd_o  (chan_period)
    );

    pwm_irq_ctl #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .sel        (sel),
        .wbits      (bus_wdata[NCH-1:0]),
        .period_end (period_end),
        .en_o       (chan_en),
        .mask_o     (irq_mask),
        .pend_o     (irq_pend),
        .irq_o      (irq)
    );

    typedef struct packed {
        logic [31:0] gmode;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic [31:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_MODE:  rd_val = st_q.gmode;
            SEL_SR:    rd_val[NCH-1:0]  = chan_en;
            SEL_IMR:   rd_val[NCH-1:0]  = irq_mask;
            SEL_ISR:   rd_val[NCH-1:0]  = irq_pend;
            SEL_CMODE: rd_val[CM_W-1:0] = chan_mode[int'(chan)*CM_W +: CM_W];
            SEL_CDUTY: rd_val[DW-1:0]   = chan_duty[int'(chan)*DW +: DW];
            SEL_CPRD:  rd_val[DW-1:0]   = chan_period[int'(chan)*DW +: DW];
            SEL_CCNT:  rd_val[DW-1:0]   = chan_count[int'(chan)*DW +: DW];
            default:   rd_val = '0;
        endcase

        st_d       = st_q;
        st_d.rdata = bus_rd ? rd_val : '0;
        if (bus_wr && sel == SEL_MODE) st_d.gmode = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/pwm_ctl_chk.sv
module pwm_ctl_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NCH-1:0]    period_end,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    mask,
    input logic [NCH-1:0]    pend,
    input logic              irq
);

    // R1
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h04)) |=>
        ((chan_en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    // R1
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h08)) |=>
        ((chan_en & $past(bus_wdata[NCH-1:0])) == '0));

    // R2
    ier_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h10)) |=>
        ((mask & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    // R2
    idr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h14)) |=>
        ((mask & $past(bus_wdata[NCH-1:0])) == '0));

    // R3
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end != '0) |=> ((pend & $past(period_end)) == $past(period_end)));

    // R4
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h1C) && period_end == '0) |=> (pend == '0));

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h0C)) |=> ($stable(chan_en) && $stable(mask)));

    // R9
    wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h04)) |=> (bus_rdata == '0));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind pwm_ctl_regs pwm_ctl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_end (period_end),
    .chan_en    (chan_en),
    .mask       (irq_mask),
    .pend       (irq_pend),
    .irq        (irq)
);

// File: tb/tb_pwm_ctl_regs.sv
module tb_pwm_ctl_regs;

    localparam int NCH  = 4;
    localparam int AW   = 10;
    localparam int CM_W = 11;
    localparam int DW   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    period_end = '0;
    logic [NCH*DW-1:0] chan_count = '0;
    logic [NCH-1:0]    chan_en;
    logic [NCH*CM_W-1:0] chan_mode;
    logic [NCH*DW-1:0] chan_duty;
    logic [NCH*DW-1:0] chan_period;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwm_ctl_regs #(.NCH(NCH), .ADDR_W(AW), .CM_W(CM_W), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_end(period_end), .chan_count(chan_count), .chan_en(chan_en),
        .chan_mode(chan_mode), .chan_duty(chan_duty), .chan_period(chan_period),
        .irq(irq)
    );

    // reference state
    logic [31:0]     m_gmode = '0;
    logic [NCH-1:0]  m_en = '0, m_mask = '0, m_pend = '0;
    logic [CM_W-1:0] m_cmode [NCH];
    logic [DW-1:0]   m_duty  [NCH];
    logic [DW-1:0]   m_prd   [NCH];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [AW-1:0] rel;
        int ch;
        model_read = '0;
        if (a[1:0] != 2'b00) return '0;
        if (a < AW'('h200)) begin
            case (a)
                AW'('h00): model_read = m_gmode;
                AW'('h0C): model_read = 32'(m_en);
                AW'('h18): model_read = 32'(m_mask);
                AW'('h1C): model_read = 32'(m_pend);
                default:   model_read = '0;
            endcase
        end else begin
            rel = a - AW'('h200);
            ch  = int'(rel >> 5);
            if (ch >= NCH) return '0;
            case (rel[4:0])
                5'h00: model_read = 32'(m_cmode[ch]);
                5'h04: model_read = 32'(m_duty[ch]);
                5'h08: model_read = 32'(m_prd[ch]);
                5'h0C: model_read = 32'(chan_count[ch*DW +: DW]);
                default: model_read = '0;
            endcase
        end
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        logic [AW-1:0] rel;
        if (a[1:0] != 2'b00) return "R9";
        if (a < AW'('h200)) begin
            case (a)
                AW'('h00): return "R6";
                AW'('h0C): return "R1";
                AW'('h18): return "R2";
                AW'('h1C): return "R4";
                default:   return "R9";
            endcase
        end
        rel = a - AW'('h200);
        if (int'(rel >> 5) >= NCH) return "R9";
        case (rel[4:0])
            5'h00, 5'h04, 5'h08: return "R7";
            5'h0C: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        logic [AW-1:0] rel;
        int ch;
        if (a[1:0] != 2'b00) return;
        if (a < AW'('h200)) begin
            case (a)
                AW'('h00): m_gmode = d;
                AW'('h04): m_en   = m_en | d[NCH-1:0];
                AW'('h08): m_en   = m_en & ~d[NCH-1:0];
                AW'('h10): m_mask = m_mask | d[NCH-1:0];
                AW'('h14): m_mask = m_mask & ~d[NCH-1:0];
                default: ;
            endcase
        end else begin
            rel = a - AW'('h200);
            ch  = int'(rel >> 5);
            if (ch >= NCH) return;
            case (rel[4:0])
                5'h00: m_cmode[ch] = d[CM_W-1:0];
                5'h04: m_duty[ch]  = d[DW-1:0];
                5'h08: m_prd[ch]   = d[DW-1:0];
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [NCH-1:0] pe);
        logic [31:0] exp_rd;
        string tg;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; period_end = pe;
        exp_rd = r ? model_read(a) : '0;
        tg     = r ? tag_of(a) : "R10";
        if (w) model_write(a, d);
        if (r && a == AW'('h1C)) m_pend = pe;   // R4 read clears, event survives
        else                     m_pend = m_pend | pe;   // R3
        @(negedge clk);
        chk(tg, bus_rdata, exp_rd);
        chk("R1", 32'(chan_en), 32'(m_en));
        chk("R5", 32'(irq), 32'(|(m_pend & m_mask)));
        for (int i = 0; i < NCH; i++) begin
            chk("R7", 32'(chan_mode[i*CM_W +: CM_W]), 32'(m_cmode[i]));
            chk("R7", 32'(chan_duty[i*DW +: DW]), 32'(m_duty[i]));
            chk("R7", 32'(chan_period[i*DW +: DW]), 32'(m_prd[i]));
        end
        bus_wr = 1'b0; bus_rd = 1'b0; period_end = '0;
    endtask

    function automatic logic [AW-1:0] rand_addr();
        int r = int'($urandom % 20);
        int ch;
        if (r < 8)   return AW'(r * 4);
        if (r == 8)  return AW'('h40 + ($urandom % 32) * 4);
        if (r == 9)  return AW'('h201 + ($urandom % 3));
        ch = int'($urandom % (NCH + 1));
        return AW'('h200 + ch * 'h20 + int'($urandom % 6) * 4);
    endfunction

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_cmode[i] = '0; m_duty[i] = '0; m_prd[i] = '0;
        end
        void'($urandom(32'd2718));
        chan_count = {16'h1357, 16'hBEEF, 16'h0042, 16'hA5A5};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", bus_rdata, '0);
        chk("R11", 32'(irq), '0);
        chk("R11", 32'(chan_en), '0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, 1, AW'('h00), 0, 0);     // R11 mode word zero
        cyc(0, 1, AW'('h1C), 0, 0);     // R11 pending zero

        // R1 set, zero-bit write, clear
        cyc(1, 0, AW'('h04), 32'hA, 0);
        cyc(1, 0, AW'('h04), 32'h0, 0);
        cyc(1, 0, AW'('h08), 32'h2, 0);
        cyc(0, 1, AW'('h0C), 0, 0);
        // R2 mask set, zero-bit clear, readback
        cyc(1, 0, AW'('h10), 32'h5, 0);
        cyc(1, 0, AW'('h14), 32'h0, 0);
        cyc(0, 1, AW'('h18), 0, 0);
        // R3 / R5 event on unmasked and masked channel
        cyc(0, 0, 0, 0, 4'b0010);
        cyc(0, 0, 0, 0, 4'b0001);
        cyc(0, 1, AW'('h1C), 0, 0);
        // R4 event in the same cycle as the status read
        cyc(0, 0, 0, 0, 4'b0100);
        cyc(0, 1, AW'('h1C), 0, 4'b0100);
        cyc(0, 1, AW'('h1C), 0, 0);
        // R6 / R7 / R8 storage and counter
        cyc(1, 0, AW'('h00), 32'hDEAD_BEEF, 0);
        cyc(0, 1, AW'('h00), 0, 0);
        cyc(1, 0, AW'('h260), 32'hFFFF_FFFF, 0);
        cyc(0, 1, AW'('h260), 0, 0);
        cyc(1, 0, AW'('h22C), 32'h1234, 0);
        cyc(0, 1, AW'('h22C), 0, 0);
        // R9 writes to read-only, reserved reads, misaligned, out-of-range slot
        cyc(1, 0, AW'('h0C), 32'hF, 0);
        cyc(1, 0, AW'('h1C), 32'hF, 0);
        cyc(0, 1, AW'('h04), 0, 0);
        cyc(0, 1, AW'('h210), 0, 0);
        cyc(0, 1, AW'('h040), 0, 0);
        cyc(0, 1, AW'('h206), 0, 0);
        cyc(1, 0, AW'('h280), 32'h7FF, 0);
        cyc(0, 1, AW'('h280), 0, 0);

        // random traffic
        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] a = rand_addr();
            logic [NCH-1:0] pe = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
            int op = int'($urandom % 10);
            if (k % 97 == 0) chan_count = {$urandom, $urandom};
            if (op < 4)      cyc(1, 0, a, $urandom, pe);
            else if (op < 8) cyc(0, 1, a, 0, pe);
            else             cyc(0, 1, AW'('h1C), 0, pe);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule